// File: doc/BRIEF.md
# Data Access Permission Checker

This block judges one data memory access after address translation and decides whether it may proceed or must fault. It receives the virtual address and access size, the read or write flag, the current privilege and hyperprivilege state, the 32-bit address-mask mode, three address-space class flags (no-fault, real, implicit), the translation lookup's hit indication, and the matched entry's attribute bits and physical address. It returns a fault code and, for accepted accesses, either a translated physical address with an uncacheable flag or a bypass indication with the address passed straight through.

The checks run in a fixed priority order. Size alignment comes first. Address masking then narrows the address, and the narrowed address is tested against the unimplemented address hole. The hyperprivileged bypass is taken next. After that the lookup result is examined for a miss, and a hit's attributes are checked for privilege, write protection and the interplay between no-fault pages and side-effect pages. Every fault raised at or after the miss check also asks the surrounding logic to capture the tag-access register.

The decision is combinational. The result is registered and presented one clock after the request is accepted.

Top module: `dperm_check`

## Requirements
- R1: A response (`rsp_valid`=1) appears exactly one clock after each cycle with `req_valid`=1. In any cycle without a response, `rsp_fault` is 0 and `rsp_tag_cap`, `rsp_bypass`, `rsp_uncache` and `rsp_pa` are all 0.
- R2: The access size is 2^`req_size_log2` bytes. If the address AND (size-1) is nonzero, the fault code is 1 (misaligned). This check overrides every other fault and the bypass.
- R3: With `st_amask`=1, address bits 63:32 are treated as zero before the hole check and before the bypass address is formed.
- R4: If address bits 63:47 are neither all zero nor all one, the fault code is 2 (out of range). This check ranks below R2 and above every later check.
- R5: With `st_hpriv`=1 and `asi_implicit`=1, and no R2 or R4 fault, the response has fault 0, `rsp_bypass`=1 and `rsp_pa` = the address bits 39:0. The lookup result and the entry attributes are ignored.
- R6: On a lookup miss, the fault code is 3 when `asi_real`=1 and 4 otherwise.
- R7: On a hit, an access with both `st_priv`=0 and `st_hpriv`=0 to an entry with `pte_priv`=1 gets fault 5. This check ranks above R8 to R10.
- R8: On a hit, a write to an entry with `pte_writable`=0 gets fault 6. This check ranks above R9 and R10.
- R9: On a hit, an entry with `pte_nofault`=1 accessed with `asi_nofault`=0 gets fault 7. This check ranks above R10.
- R10: On a hit, an entry with `pte_side`=1 accessed with `asi_nofault`=1 gets fault 8.
- R11: A hit with no fault gives fault 0, `rsp_pa`=`pte_pa`, and `rsp_uncache`=1 exactly when `pte_side`=1 or `pte_pa` bit 39 is 1. Faults and bypasses give `rsp_uncache`=0 and `rsp_pa`=0.
- R12: `rsp_tag_cap` is 1 exactly for the fault codes 3 to 8. It is 0 for codes 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access presented this cycle |
| req_va | input | VA_W | Virtual address |
| req_size_log2 | input | 2 | log2 of the access size in bytes |
| req_write | input | 1 | 1 for a store |
| st_priv | input | 1 | Privileged mode |
| st_hpriv | input | 1 | Hyperprivileged mode |
| st_amask | input | 1 | 32-bit address masking enabled |
| asi_nofault | input | 1 | Address space is a no-fault class |
| asi_real | input | 1 | Address space is a real (context-free) class |
| asi_implicit | input | 1 | Address space is the implicit one |
| tlb_hit | input | 1 | Lookup found a matching entry |
| pte_priv | input | 1 | Entry is privileged-only |
| pte_writable | input | 1 | Entry permits writes |
| pte_nofault | input | 1 | Entry is no-fault-only |
| pte_side | input | 1 | Entry has side effects |
| pte_pa | input | PA_W | Entry's physical address |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 4 | Fault code, 0 = none |
| rsp_uncache | output | 1 | Access must bypass caches |
| rsp_bypass | output | 1 | Translation bypassed |
| rsp_tag_cap | output | 1 | Capture the tag-access register |
| rsp_pa | output | PA_W | Resulting physical address |

## Verification
The bench builds the block with its default values: a 64-bit address, 48 implemented address bits, a 40-bit physical address, and bit 39 as the uncacheable marker. These values place the hole edges at 0x0000_7FFF_FFFF_FFF8 and 0xFFFF_8000_0000_0000, so both sides of each edge can be driven directly. The 40-bit physical width lets a bypassed address show that bits above 39 are dropped and that bit 39 alone marks a page uncacheable. Stacked fault conditions are applied so that each priority step is observed overriding the steps below it.

// File: rtl/dperm_pkg.sv
package dperm_pkg;

  typedef enum logic [3:0] {
    FLT_NONE      = 4'd0,
    FLT_MISALIGN  = 4'd1,
    FLT_RANGE     = 4'd2,
    FLT_MISS_REAL = 4'd3,
    FLT_MISS_MMU  = 4'd4,
    FLT_PRIV      = 4'd5,
    FLT_PROT      = 4'd6,
    FLT_NFO       = 4'd7,
    FLT_SIDE      = 4'd8
  } fault_e;

  // first fault code of the group that requests a tag capture
  localparam int ATTR_BASE = 3;
  localparam int N_ATTR    = 6;

  // size is 2**szlog bytes; low address bits must be clear
  function automatic logic size_misaligned(input logic [2:0] va_lo,
                                           input logic [1:0] szlog);
    logic [3:0] span;
    span = (4'd1 << szlog) - 4'd1;
    return |(va_lo & span[2:0]);
  endfunction

endpackage

// File: rtl/dperm_addr_stage.sv
module dperm_addr_stage
  import dperm_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int PA_W    = 40
) (
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      szlog,
  input  logic            amask,
  input  logic            hpriv,
  input  logic            implicit_asi,
  output logic            misalign,
  output logic            out_of_range,
  output logic            bypass_req,
  output logic [PA_W-1:0] bypass_pa
);

  localparam int HI_W = VA_W - 32;

  logic [VA_W-1:0] eff_va;
  logic            unused_va_bits;

  assign eff_va     = amask ? {{HI_W{1'b0}}, va[31:0]} : va;
  assign misalign   = size_misaligned(va[2:0], szlog);
  assign bypass_req = hpriv & implicit_asi;
  assign bypass_pa  = eff_va[PA_W-1:0];
  assign unused_va_bits = ^eff_va;

  generate
    if (VA_IMPL < VA_W) begin : g_hole
      localparam int TOP_N = VA_W - VA_IMPL + 1;
      logic [TOP_N-1:0] top_bits;
      assign top_bits     = eff_va[VA_W-1:VA_IMPL-1];
      assign out_of_range = !((&top_bits) || !(|top_bits));
    end else begin : g_nohole
      assign out_of_range = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dperm_attr_stage.sv
module dperm_attr_stage
  import dperm_pkg::*;
(
  input  logic              tlb_hit,
  input  logic              asi_real,
  input  logic              asi_nofault,
  input  logic              nonpriv,
  input  logic              is_write,
  input  logic              pte_priv,
  input  logic              pte_writable,
  input  logic              pte_nofault,
  input  logic              pte_side,
  output logic [N_ATTR-1:0] causes,
  output fault_e            fault
);

  // index order is priority order, lowest index wins
  assign causes[0] = !tlb_hit & asi_real;
  assign causes[1] = !tlb_hit & !asi_real;
  assign causes[2] = tlb_hit & nonpriv & pte_priv;
  assign causes[3] = tlb_hit & is_write & !pte_writable;
  assign causes[4] = tlb_hit & pte_nofault & !asi_nofault;
  assign causes[5] = tlb_hit & pte_side & asi_nofault;

  always_comb begin
    fault = FLT_NONE;
    for (int i = N_ATTR - 1; i >= 0; i--) begin
      if (causes[i]) fault = fault_e'(4'(i + ATTR_BASE));
    end
  end

endmodule

// File: rtl/dperm_check.sv
module dperm_check
  import dperm_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int PA_W    = 40,
  parameter int UNC_BIT = 39
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_va,
  input  logic [1:0]      req_size_log2,
  input  logic            req_write,
  input  logic            st_priv,
  input  logic            st_hpriv,
  input  logic            st_amask,
  input  logic            asi_nofault,
  input  logic            asi_real,
  input  logic            asi_implicit,
  input  logic            tlb_hit,
  input  logic            pte_priv,
  input  logic            pte_writable,
  input  logic            pte_nofault,
  input  logic            pte_side,
  input  logic [PA_W-1:0] pte_pa,
  output logic            rsp_valid,
  output logic [3:0]      rsp_fault,
  output logic            rsp_uncache,
  output logic            rsp_bypass,
  output logic            rsp_tag_cap,
  output logic [PA_W-1:0] rsp_pa
);

  // named internal events, observed by the bound checker
  logic              w_misalign;
  logic              w_range;
  logic              w_bypass;
  logic [PA_W-1:0]   w_bypass_pa;
  logic [N_ATTR-1:0] w_causes;
  fault_e            w_attr_fault;

  fault_e            nxt_fault;
  logic              nxt_unc;
  logic              nxt_byp;
  logic              nxt_tag;
  logic [PA_W-1:0]   nxt_pa;

  dperm_addr_stage #(
    .VA_W   (VA_W),
    .VA_IMPL(VA_IMPL),
    .PA_W   (PA_W)
  ) u_addr (
    .va          (req_va),
    .szlog       (req_size_log2),
    .amask       (st_amask),
    .hpriv       (st_hpriv),
    .implicit_asi(asi_implicit),
    .misalign    (w_misalign),
    .out_of_range(w_range),
    .bypass_req  (w_bypass),
    .bypass_pa   (w_bypass_pa)
  );

  dperm_attr_stage u_attr (
    .tlb_hit     (tlb_hit),
    .asi_real    (asi_real),
    .asi_nofault (asi_nofault),
    .nonpriv     (!st_priv && !st_hpriv),
    .is_write    (req_write),
    .pte_priv    (pte_priv),
    .pte_writable(pte_writable),
    .pte_nofault (pte_nofault),
    .pte_side    (pte_side),
    .causes      (w_causes),
    .fault       (w_attr_fault)
  );

  always_comb begin
    nxt_fault = FLT_NONE;
    nxt_unc   = 1'b0;
    nxt_byp   = 1'b0;
    nxt_tag   = 1'b0;
    nxt_pa    = '0;
    if (w_misalign) begin
      nxt_fault = FLT_MISALIGN;
    end else if (w_range) begin
      nxt_fault = FLT_RANGE;
    end else if (w_bypass) begin
      nxt_byp = 1'b1;
      nxt_pa  = w_bypass_pa;
    end else if (w_attr_fault != FLT_NONE) begin
      nxt_fault = w_attr_fault;
      nxt_tag   = 1'b1;
    end else begin
      nxt_pa  = pte_pa;
      nxt_unc = pte_side | pte_pa[UNC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= FLT_NONE;
      rsp_uncache <= 1'b0;
      rsp_bypass  <= 1'b0;
      rsp_tag_cap <= 1'b0;
      rsp_pa      <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_fault   <= req_valid ? nxt_fault : FLT_NONE;
      rsp_uncache <= req_valid & nxt_unc;
      rsp_bypass  <= req_valid & nxt_byp;
      rsp_tag_cap <= req_valid & nxt_tag;
      rsp_pa      <= req_valid ? nxt_pa : '0;
    end
  end

endmodule

// File: rtl/dperm_check_sva.sv
module dperm_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       w_misalign,
  input logic       w_range,
  input logic       rsp_valid,
  input logic [3:0] rsp_fault,
  input logic       rsp_uncache,
  input logic       rsp_bypass,
  input logic       rsp_tag_cap
);

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_fault == 4'd0 && !rsp_tag_cap && !rsp_bypass && !rsp_uncache));

  // R2
  misalign_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && w_misalign) |=> (rsp_fault == 4'd1));

  // R4
  range_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !w_misalign && w_range) |=> (rsp_fault == 4'd2));

  // R5
  bypass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bypass |-> (rsp_fault == 4'd0 && !rsp_uncache && !rsp_tag_cap));

  // R11
  uncache_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncache |-> (rsp_fault == 4'd0 && !rsp_bypass));

  // R12
  tagcap_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_tag_cap == (rsp_fault >= 4'd3 && rsp_fault <= 4'd8)));

endmodule

bind dperm_check dperm_check_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .w_misalign (w_misalign),
  .w_range    (w_range),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_uncache(rsp_uncache),
  .rsp_bypass (rsp_bypass),
  .rsp_tag_cap(rsp_tag_cap)
);

// File: tb/dperm_check_tb.sv
module dperm_check_tb_top;

  localparam int CLK_P = 10;
  localparam int VA_W  = 64;
  localparam int PA_W  = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid;
  logic [VA_W-1:0] req_va;
  logic [1:0]      req_size_log2;
  logic            req_write, st_priv, st_hpriv, st_amask;
  logic            asi_nofault, asi_real, asi_implicit, tlb_hit;
  logic            pte_priv, pte_writable, pte_nofault, pte_side;
  logic [PA_W-1:0] pte_pa;
  logic            rsp_valid, rsp_uncache, rsp_bypass, rsp_tag_cap;
  logic [3:0]      rsp_fault;
  logic [PA_W-1:0] rsp_pa;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_P/2) clk = ~clk;

  dperm_check dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_size_log2(req_size_log2), .req_write(req_write), .st_priv(st_priv),
    .st_hpriv(st_hpriv), .st_amask(st_amask), .asi_nofault(asi_nofault),
    .asi_real(asi_real), .asi_implicit(asi_implicit), .tlb_hit(tlb_hit),
    .pte_priv(pte_priv), .pte_writable(pte_writable), .pte_nofault(pte_nofault),
    .pte_side(pte_side), .pte_pa(pte_pa), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_uncache(rsp_uncache), .rsp_bypass(rsp_bypass),
    .rsp_tag_cap(rsp_tag_cap), .rsp_pa(rsp_pa)
  );

  task automatic clear_in();
    req_valid = 0; req_va = 64'h0000_0000_0000_1000; req_size_log2 = 2'd0;
    req_write = 0; st_priv = 0; st_hpriv = 0; st_amask = 0;
    asi_nofault = 0; asi_real = 0; asi_implicit = 0; tlb_hit = 1;
    pte_priv = 0; pte_writable = 1; pte_nofault = 0; pte_side = 0;
    pte_pa = 40'h00_1234_5000;
  endtask

  // inputs were set after a falling edge; register at the rising edge
  task automatic fire();
    req_valid = 1;
    @(posedge clk); #1;
  endtask

  task automatic expect_rsp(input string rq, input int f, input bit tag,
                            input bit byp, input bit unc, input logic [PA_W-1:0] pa);
    n_tests++;
    if (rsp_valid !== 1'b1 || rsp_fault !== 4'(f) || rsp_tag_cap !== tag ||
        rsp_bypass !== byp || rsp_uncache !== unc || rsp_pa !== pa) begin
      n_fail++;
      $display("FAIL %s: got v=%0b fault=%0d tag=%0b byp=%0b unc=%0b pa=%h ; expected v=1 fault=%0d tag=%0b byp=%0b unc=%0b pa=%h",
               rq, rsp_valid, rsp_fault, rsp_tag_cap, rsp_bypass, rsp_uncache, rsp_pa,
               f, tag, byp, unc, pa);
    end
  endtask

  task automatic expect_quiet(input string rq);
    n_tests++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 4'd0 || rsp_tag_cap !== 1'b0 ||
        rsp_bypass !== 1'b0 || rsp_uncache !== 1'b0 || rsp_pa !== '0) begin
      n_fail++;
      $display("FAIL %s: got v=%0b fault=%0d tag=%0b byp=%0b unc=%0b pa=%h ; expected all zero",
               rq, rsp_valid, rsp_fault, rsp_tag_cap, rsp_bypass, rsp_uncache, rsp_pa);
    end
  endtask

  task automatic t_reset_idle();
    clear_in();
    req_valid = 1; req_va = 64'h0000_8000_0000_0003; req_size_log2 = 2'd2;
    repeat (3) @(posedge clk);
    #1 expect_quiet("R1 reset state");
    @(negedge clk); rst_n = 1; req_valid = 0;
    @(posedge clk); #1 expect_quiet("R1 idle cycle with faulting inputs");
  endtask

  task automatic t_misalign();
    @(negedge clk); clear_in(); req_va = 64'h4; req_size_log2 = 2'd3; fire();
    expect_rsp("R2 8-byte at offset 4", 1, 0, 0, 0, '0);
    @(negedge clk); clear_in(); req_va = 64'h0000_8000_0000_0002; req_size_log2 = 2'd2;
    tlb_hit = 0; st_hpriv = 1; asi_implicit = 1; fire();
    expect_rsp("R2 over hole, bypass and miss", 1, 0, 0, 0, '0);
    @(negedge clk); clear_in(); req_va = 64'h1003; req_size_log2 = 2'd0; fire();
    expect_rsp("R2 byte access odd address", 0, 0, 0, 0, 40'h00_1234_5000);
    @(negedge clk); clear_in(); req_va = 64'h1006; req_size_log2 = 2'd1; fire();
    expect_rsp("R2 halfword aligned", 0, 0, 0, 0, 40'h00_1234_5000);
  endtask

  task automatic t_range();
    @(negedge clk); clear_in(); req_va = 64'h0000_8000_0000_0000; tlb_hit = 0; fire();
    expect_rsp("R4 first hole address", 2, 0, 0, 0, '0);
    @(negedge clk); clear_in(); req_va = 64'h0000_7FFF_FFFF_FFF8; req_size_log2 = 2'd3; fire();
    expect_rsp("R4 top of low half", 0, 0, 0, 0, 40'h00_1234_5000);
    @(negedge clk); clear_in(); req_va = 64'hFFFF_8000_0000_0000; fire();
    expect_rsp("R4 bottom of high half", 0, 0, 0, 0, 40'h00_1234_5000);
    @(negedge clk); clear_in(); req_va = 64'hFFFF_7FFF_FFFF_FFF8; st_hpriv = 1; asi_implicit = 1; fire();
    expect_rsp("R4 last hole address beats bypass", 2, 0, 0, 0, '0);
  endtask

  task automatic t_amask();
    @(negedge clk); clear_in(); req_va = 64'h0000_8000_1234_5678; st_amask = 1;
    st_hpriv = 1; asi_implicit = 1; fire();
    expect_rsp("R3 masked bypass address", 0, 0, 1, 0, 40'h00_1234_5678);
    @(negedge clk); clear_in(); req_va = 64'h1234_0000_0000_0000; st_amask = 1; fire();
    expect_rsp("R3 masked hole address hits", 0, 0, 0, 0, 40'h00_1234_5000);
  endtask

  task automatic t_bypass();
    @(negedge clk); clear_in(); req_va = 64'hFFFF_FFAB_CDEF_0000; st_hpriv = 1; asi_implicit = 1;
    tlb_hit = 0; pte_side = 1; fire();
    expect_rsp("R5 bypass ignores miss, drops high bits", 0, 0, 1, 0, 40'hAB_CDEF_0000);
    @(negedge clk); clear_in(); st_hpriv = 1; tlb_hit = 0; fire();
    expect_rsp("R5 hpriv without implicit takes miss", 4, 1, 0, 0, '0);
  endtask

  task automatic t_miss();
    @(negedge clk); clear_in(); tlb_hit = 0; asi_real = 1; fire();
    expect_rsp("R6 real miss", 3, 1, 0, 0, '0);
    @(negedge clk); clear_in(); tlb_hit = 0; pte_priv = 1; req_write = 1; pte_writable = 0; fire();
    expect_rsp("R6 mmu miss ignores entry bits", 4, 1, 0, 0, '0);
  endtask

  task automatic t_priv_prot();
    @(negedge clk); clear_in(); pte_priv = 1; req_write = 1; pte_writable = 0; pte_nofault = 1; fire();
    expect_rsp("R7 user to priv page over R8", 5, 1, 0, 0, '0);
    @(negedge clk); clear_in(); st_priv = 1; pte_priv = 1; req_write = 1; pte_writable = 0;
    pte_nofault = 1; fire();
    expect_rsp("R8 priv write to read-only over R9", 6, 1, 0, 0, '0);
    @(negedge clk); clear_in(); st_hpriv = 1; pte_priv = 1; fire();
    expect_rsp("R7 hpriv reads priv page", 0, 0, 0, 0, 40'h00_1234_5000);
    @(negedge clk); clear_in(); pte_writable = 0; fire();
    expect_rsp("R8 read of read-only page", 0, 0, 0, 0, 40'h00_1234_5000);
  endtask

  task automatic t_nofault_side();
    @(negedge clk); clear_in(); pte_nofault = 1; pte_side = 1; fire();
    expect_rsp("R9 no-fault page, normal asi", 7, 1, 0, 0, '0);
    @(negedge clk); clear_in(); pte_nofault = 1; asi_nofault = 1; fire();
    expect_rsp("R9 no-fault page, no-fault asi", 0, 0, 0, 0, 40'h00_1234_5000);
    @(negedge clk); clear_in(); pte_side = 1; asi_nofault = 1; fire();
    expect_rsp("R10 side-effect page, no-fault asi", 8, 1, 0, 0, '0);
  endtask

  task automatic t_uncache();
    @(negedge clk); clear_in(); pte_side = 1; pte_pa = 40'h00_0000_2000; fire();
    expect_rsp("R11 side-effect page uncacheable", 0, 0, 0, 1, 40'h00_0000_2000);
    @(negedge clk); clear_in(); pte_pa = 40'h80_0000_3000; fire();
    expect_rsp("R11 pa bit 39 uncacheable", 0, 0, 0, 1, 40'h80_0000_3000);
    @(negedge clk); clear_in(); pte_pa = 40'h7F_FFFF_F000; fire();
    expect_rsp("R11 pa bit 38 cacheable", 0, 0, 0, 0, 40'h7F_FFFF_F000);
    @(negedge clk); clear_in(); st_hpriv = 1; asi_implicit = 1; req_va = 64'h80_0000_0000; fire();
    expect_rsp("R11 R12 bypass never uncacheable", 0, 0, 1, 0, 40'h80_0000_0000);
    @(negedge clk); clear_in();
    @(posedge clk); #1 expect_quiet("R1 response drops after request");
  endtask

  initial begin
    clear_in();
    t_reset_idle();
    t_misalign();
    t_range();
    t_amask();
    t_bypass();
    t_miss();
    t_priv_prot();
    t_nofault_side();
    t_uncache();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got no completion, expected end of test list");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule